// File: doc/BRIEF.md
# Descriptor-Chained Transmit DMA Channel

This block is one transmit DMA channel. It walks a linked list of four-word buffer descriptors held in a word-addressed local memory and sends the bytes of each buffer out on a byte stream with valid/ready flow control. Software loads the address of the first descriptor into a head register, and the channel then follows the next pointers until it finds a zero. Each finished descriptor is handed back to software by clearing its ownership bit in the mode word. The last descriptor of a chain also gets its end-of-queue bit set, so software can tell whether a descriptor appended late was missed and restart the channel by loading the head register again.

Software acknowledges finished work through a completion register. A pending flag stays up until the value written there equals the last descriptor the channel finished. A descriptor fetched while software still owns it stops the channel with a fault flag and sends nothing. An enable bit gates the fetch of each new descriptor, and a self-clearing soft reset returns the channel to rest.

The sequencer has nine states:
- **IDLE**: waits for a non-zero head.
- **DREQ / DCAP**: request and capture each descriptor word.
- **CHECK**: tests ownership and length.
- **BREQ / BCAP**: request and capture a buffer word.
- **SEND**: presents bytes.
- **WBACK**: writes the mode word back.
- **FAULT**: stops on a descriptor not owned by the channel.

The transitions are:
- IDLE→DREQ when the head is non-zero.
- DREQ→DCAP when enabled, or at once for the second and later words of a descriptor.
- DCAP→DREQ after words 0 to 2, and DCAP→CHECK after word 3.
- CHECK→FAULT when the ownership bit is clear, CHECK→WBACK when the length is zero, otherwise CHECK→BREQ.
- BREQ→BCAP→SEND.
- SEND→BREQ after the fourth byte of a word, and SEND→WBACK after the last byte.
- WBACK→DREQ when the next pointer is non-zero, otherwise WBACK→IDLE.
- FAULT→IDLE.
- Any state→IDLE on soft reset.

Top module: `txq_dma_chan`

## Requirements
- R1: After reset the head, completion and control registers read 0, `tx_valid`, `ch_busy`, `ch_fault` and `cmpl_pending` are 0. The register select codes are: 0 control (bit 0 = enable), 1 head pointer, 2 completion pointer, 3 soft reset (bit 0).
- R2: Writing a non-zero value to the head register while the channel is idle starts the channel. It reads the descriptor words at addresses d, d+1, d+2, d+3: next pointer, buffer pointer, buffer length, mode. Pointers are word addresses, of which the low `PTR_W` bits are used.
- R3: The channel sends as many bytes as the low 11 bits of the buffer-length word give. Byte i of a buffer is byte lane i mod 4 (lane 0 = bits 7:0) of word buffer+i/4. `tx_sop` marks the first byte when mode bit 31 is set, and `tx_eop` marks the last byte when mode bit 30 is set. A zero length sends nothing.
- R4: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data`, `tx_sop` and `tx_eop` hold.
- R5: After the last byte, the channel writes back the mode word before any further fetch. The written word has bit 29 (ownership) cleared, bit 28 equal to 1 exactly when the next pointer is zero, and all other bits unchanged.
- R6: After finishing a descriptor with a zero next pointer, the channel is idle and the head reads 0. A descriptor linked in after that point is not fetched until the head is written again.
- R7: A non-zero next pointer is followed without software action, and the bytes of all descriptors in a chain come out in chain order.
- R8: A fetched descriptor with mode bit 29 clear sets `ch_fault`. No bytes are sent, no write-back happens, the channel goes idle and the head reads 0. `ch_fault` clears on the next accepted non-zero head write or on a soft reset.
- R9: `cmpl_pending` rises when a descriptor is finished. A completion-register write clears it only when the written value equals the address of the last finished descriptor; any other value leaves it set.
- R10: With enable at 0 the channel fetches no new descriptor: a head written while disabled stays in the head register and waits. Setting enable to 1 lets it proceed.
- R11: Writing 1 to bit 0 of the soft-reset register makes that register read 1 for one cycle and then 0. It clears the head, completion, pending and fault state and aborts any transfer without a write-back.
- R12: A head write while the channel is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_wsel | input | 2 | Register select for writes |
| reg_wdata | input | 32 | Register write data |
| reg_rsel | input | 2 | Register select for reads |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (with `mem_req`) |
| mem_addr | output | PTR_W | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after the request |
| tx_valid | output | 1 | Byte stream valid |
| tx_ready | input | 1 | Byte stream ready |
| tx_data | output | 8 | Byte stream data |
| tx_sop | output | 1 | First byte of a packet |
| tx_eop | output | 1 | Last byte of a packet |
| ch_busy | output | 1 | Channel not idle |
| ch_fault | output | 1 | Ownership fault seen |
| cmpl_pending | output | 1 | Finished descriptor not yet acknowledged |

## Verification
- **Start-up timing:** a head write takes effect at the edge that samples it. The first descriptor read is requested one cycle later, and each descriptor word costs two cycles. A buffer word costs two cycles before its first byte appears.
- **Sampling:** the write-back and the head clear land at the same edge, one cycle after the last byte is accepted. The bench does not predict those cycle counts; it waits for `ch_busy` to fall and then reads registers and memory at a falling edge.
- **Soft reset:** the soft-reset bit is read at the falling edge right after the sampling edge, and again one cycle later.
- **Sweep:** buffer lengths 0 to 9 are swept against all four start/end flag combinations, with and without backpressure. The expected bytes come from an arithmetic fill pattern of the memory.

// File: rtl/txq_pkg.sv
`timescale 1ns/1ps
package txq_pkg;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned LEN_W   = 11;
    localparam int unsigned SOP_BIT = 31;
    localparam int unsigned EOP_BIT = 30;
    localparam int unsigned OWN_BIT = 29;
    localparam int unsigned EOQ_BIT = 28;

    localparam logic [1:0] SEL_CTRL  = 2'd0;
    localparam logic [1:0] SEL_HEAD  = 2'd1;
    localparam logic [1:0] SEL_CMPL  = 2'd2;
    localparam logic [1:0] SEL_SRST  = 2'd3;

    typedef enum logic [3:0] {
        S_IDLE  = 4'd0,
        S_DREQ  = 4'd1,
        S_DCAP  = 4'd2,
        S_CHECK = 4'd3,
        S_BREQ  = 4'd4,
        S_BCAP  = 4'd5,
        S_SEND  = 4'd6,
        S_WBACK = 4'd7,
        S_FAULT = 4'd8
    } seq_state_e;
endpackage

// File: rtl/txq_lane.sv
`timescale 1ns/1ps
module txq_lane #(
    parameter int unsigned BYTES = 4
) (
    input  logic [8*BYTES-1:0]         word_i,
    input  logic [$clog2(BYTES)-1:0]   sel_i,
    output logic [7:0]                 byte_o
);
    logic [7:0] lanes [BYTES];

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        assign lanes[g] = word_i[8*g +: 8];
    end

    assign byte_o = lanes[sel_i];
endmodule

// File: rtl/txq_regs.sv
`timescale 1ns/1ps
module txq_regs
    import txq_pkg::*;
#(
    parameter int unsigned PTR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    output logic [WORD_W-1:0] rd_data,
    input  logic              seq_idle,
    input  logic              hw_head_we,
    input  logic [PTR_W-1:0]  hw_head_val,
    input  logic              hw_done,
    input  logic [PTR_W-1:0]  hw_done_ptr,
    input  logic              hw_fault,
    output logic              enable_o,
    output logic [PTR_W-1:0]  head_o,
    output logic              srst_o,
    output logic              pend_o,
    output logic              fault_o
);
    logic             ctrl_q;
    logic [PTR_W-1:0] head_q;
    logic [PTR_W-1:0] cmpl_q;
    logic [PTR_W-1:0] last_q;
    logic             srst_q;
    logic             pend_q;
    logic             err_q;

    logic wr_ctrl, wr_head, wr_cmpl, wr_srst, head_take;

    assign wr_ctrl   = wr_en && (wr_sel == SEL_CTRL);
    assign wr_head   = wr_en && (wr_sel == SEL_HEAD);
    assign wr_cmpl   = wr_en && (wr_sel == SEL_CMPL);
    assign wr_srst   = wr_en && (wr_sel == SEL_SRST);
    assign head_take = wr_head && seq_idle && !srst_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= 1'b0;
            srst_q <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q <= wr_data[0];
            end
            srst_q <= wr_srst && wr_data[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
            cmpl_q <= '0;
            last_q <= '0;
            pend_q <= 1'b0;
            err_q  <= 1'b0;
        end else if (srst_q) begin
            head_q <= '0;
            cmpl_q <= '0;
            last_q <= '0;
            pend_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (hw_head_we) begin
                head_q <= hw_head_val;
            end else if (head_take) begin
                head_q <= wr_data[PTR_W-1:0];
            end
            if (wr_cmpl) begin
                cmpl_q <= wr_data[PTR_W-1:0];
            end
            if (hw_done) begin
                last_q <= hw_done_ptr;
            end
            if (hw_done) begin
                pend_q <= 1'b1;
            end else if (wr_cmpl) begin
                pend_q <= pend_q && (wr_data[PTR_W-1:0] != last_q);
            end
            if (hw_fault) begin
                err_q <= 1'b1;
            end else if (head_take && (wr_data[PTR_W-1:0] != '0)) begin
                err_q <= 1'b0;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_sel)
            SEL_CTRL: rd_data[0]         = ctrl_q;
            SEL_HEAD: rd_data[PTR_W-1:0] = head_q;
            SEL_CMPL: rd_data[PTR_W-1:0] = cmpl_q;
            SEL_SRST: rd_data[0]         = srst_q;
            default:  rd_data            = '0;
        endcase
    end

    assign enable_o = ctrl_q;
    assign head_o   = head_q;
    assign srst_o   = srst_q;
    assign pend_o   = pend_q;
    assign fault_o  = err_q;

    // R11: one cycle after a soft reset pulse all channel state is clear
    a_r11_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
        srst_q |=> (head_q == '0) && !pend_q && !err_q && (cmpl_q == '0));

    // R9: a finished descriptor leaves the pending flag raised
    a_r9_pend_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_done && !srst_q) |=> pend_q);
endmodule

// File: rtl/txq_seq.sv
`timescale 1ns/1ps
module txq_seq
    import txq_pkg::*;
#(
    parameter int unsigned PTR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst,
    input  logic              enable,
    input  logic [PTR_W-1:0]  head,
    output logic              mem_req,
    output logic              mem_we,
    output logic [PTR_W-1:0]  mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_sop,
    output logic              tx_eop,
    output logic              busy,
    output logic              hw_head_we,
    output logic [PTR_W-1:0]  hw_head_val,
    output logic              hw_done,
    output logic [PTR_W-1:0]  hw_done_ptr,
    output logic              hw_fault
);
    localparam int unsigned DESC_WORDS = 4;
    localparam int unsigned IDX_W      = $clog2(DESC_WORDS);
    localparam int unsigned BYTES      = WORD_W / 8;
    localparam int unsigned LANE_W     = $clog2(BYTES);

    seq_state_e state_q, state_nx;

    logic [PTR_W-1:0]  cur_q;
    logic [IDX_W-1:0]  idx_q;
    logic [WORD_W-1:0] desc_q [DESC_WORDS];
    logic [LEN_W-1:0]  rem_q;
    logic [PTR_W-1:0]  wptr_q;
    logic [WORD_W-1:0] word_q;
    logic [LANE_W-1:0] lane_q;
    logic              first_q;

    logic [PTR_W-1:0]  nxt_ptr;
    logic [PTR_W-1:0]  buf_ptr;
    logic [LEN_W-1:0]  buf_len;
    logic [WORD_W-1:0] mode_w;
    logic              nxt_zero;
    logic              last_byte;
    logic              lane_end;
    logic [WORD_W-1:0] wb_word;
    logic [7:0]        lane_byte;

    assign nxt_ptr   = desc_q[0][PTR_W-1:0];
    assign buf_ptr   = desc_q[1][PTR_W-1:0];
    assign buf_len   = desc_q[2][LEN_W-1:0];
    assign mode_w    = desc_q[3];
    assign nxt_zero  = (nxt_ptr == '0);
    assign last_byte = (rem_q == LEN_W'(1));
    assign lane_end  = (lane_q == LANE_W'(BYTES - 1));

    always_comb begin
        wb_word          = mode_w;
        wb_word[OWN_BIT] = 1'b0;
        wb_word[EOQ_BIT] = nxt_zero;
    end

    txq_lane #(.BYTES(BYTES)) u_lane (
        .word_i (word_q),
        .sel_i  (lane_q),
        .byte_o (lane_byte)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state_q;
        if (srst) begin
            state_nx = S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE:  if (head != '0) state_nx = S_DREQ;
                S_DREQ:  if ((idx_q != '0) || enable) state_nx = S_DCAP;
                S_DCAP:  state_nx = (idx_q == IDX_W'(DESC_WORDS - 1)) ? S_CHECK : S_DREQ;
                S_CHECK: begin
                    if (!mode_w[OWN_BIT])      state_nx = S_FAULT;
                    else if (buf_len == '0)    state_nx = S_WBACK;
                    else                       state_nx = S_BREQ;
                end
                S_BREQ:  state_nx = S_BCAP;
                S_BCAP:  state_nx = S_SEND;
                S_SEND: begin
                    if (tx_ready) begin
                        if (last_byte)     state_nx = S_WBACK;
                        else if (lane_end) state_nx = S_BREQ;
                    end
                end
                S_WBACK: state_nx = nxt_zero ? S_IDLE : S_DREQ;
                S_FAULT: state_nx = S_IDLE;
                default: state_nx = S_IDLE;
            endcase
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q   <= '0;
            idx_q   <= '0;
            rem_q   <= '0;
            wptr_q  <= '0;
            word_q  <= '0;
            lane_q  <= '0;
            first_q <= 1'b0;
            for (int i = 0; i < DESC_WORDS; i++) desc_q[i] <= '0;
        end else if (srst) begin
            idx_q   <= '0;
            rem_q   <= '0;
            lane_q  <= '0;
            first_q <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE:  cur_q <= head;
                S_DCAP: begin
                    desc_q[idx_q] <= mem_rdata;
                    idx_q         <= idx_q + IDX_W'(1);
                end
                S_CHECK: begin
                    rem_q   <= buf_len;
                    wptr_q  <= buf_ptr;
                    lane_q  <= '0;
                    first_q <= 1'b1;
                end
                S_BCAP:  word_q <= mem_rdata;
                S_SEND: begin
                    if (tx_ready) begin
                        rem_q   <= rem_q - LEN_W'(1);
                        lane_q  <= lane_q + LANE_W'(1);
                        first_q <= 1'b0;
                        if (lane_end) wptr_q <= wptr_q + PTR_W'(1);
                    end
                end
                S_WBACK: cur_q <= nxt_ptr;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = '0;
        mem_wdata   = '0;
        tx_valid    = 1'b0;
        tx_sop      = 1'b0;
        tx_eop      = 1'b0;
        hw_head_we  = 1'b0;
        hw_head_val = '0;
        hw_done     = 1'b0;
        hw_done_ptr = cur_q;
        hw_fault    = 1'b0;
        unique case (state_q)
            S_DREQ: begin
                mem_req  = (idx_q != '0) || enable;
                mem_addr = cur_q + PTR_W'(idx_q);
            end
            S_BREQ: begin
                mem_req  = 1'b1;
                mem_addr = wptr_q;
            end
            S_SEND: begin
                tx_valid = 1'b1;
                tx_sop   = mode_w[SOP_BIT] && first_q;
                tx_eop   = mode_w[EOP_BIT] && last_byte;
            end
            S_WBACK: begin
                mem_req     = 1'b1;
                mem_we      = 1'b1;
                mem_addr    = cur_q + PTR_W'(DESC_WORDS - 1);
                mem_wdata   = wb_word;
                hw_head_we  = 1'b1;
                hw_head_val = nxt_ptr;
                hw_done     = 1'b1;
            end
            S_FAULT: begin
                hw_head_we  = 1'b1;
                hw_head_val = '0;
                hw_fault    = 1'b1;
            end
            default: ;
        endcase
    end

    assign tx_data = lane_byte;
    assign busy    = (state_q != S_IDLE);

    // R4: a stalled byte is held unchanged
    a_r4_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !srst) |=>
            (tx_valid && $stable(tx_data) && $stable(tx_sop) && $stable(tx_eop)));

    // R3: the end-of-packet byte is followed by a gap for the write-back
    a_r3_gap_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_eop) |=> !tx_valid);

    // R5: a write-back never leaves the ownership bit set
    a_r5_owner_released: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !mem_wdata[OWN_BIT]);
endmodule

// File: rtl/txq_dma_chan.sv
`timescale 1ns/1ps
module txq_dma_chan
    import txq_pkg::*;
#(
    parameter int unsigned PTR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_wsel,
    input  logic [31:0]       reg_wdata,
    input  logic [1:0]        reg_rsel,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [PTR_W-1:0]  mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_sop,
    output logic              tx_eop,
    output logic              ch_busy,
    output logic              ch_fault,
    output logic              cmpl_pending
);
    logic             enable;
    logic [PTR_W-1:0] head;
    logic             srst;
    logic             hw_head_we;
    logic [PTR_W-1:0] hw_head_val;
    logic             hw_done;
    logic [PTR_W-1:0] hw_done_ptr;
    logic             hw_fault;
    logic             busy;

    txq_regs #(.PTR_W(PTR_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_we),
        .wr_sel      (reg_wsel),
        .wr_data     (reg_wdata),
        .rd_sel      (reg_rsel),
        .rd_data     (reg_rdata),
        .seq_idle    (!busy),
        .hw_head_we  (hw_head_we),
        .hw_head_val (hw_head_val),
        .hw_done     (hw_done),
        .hw_done_ptr (hw_done_ptr),
        .hw_fault    (hw_fault),
        .enable_o    (enable),
        .head_o      (head),
        .srst_o      (srst),
        .pend_o      (cmpl_pending),
        .fault_o     (ch_fault)
    );

    txq_seq #(.PTR_W(PTR_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .srst        (srst),
        .enable      (enable),
        .head        (head),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_rdata   (mem_rdata),
        .tx_valid    (tx_valid),
        .tx_ready    (tx_ready),
        .tx_data     (tx_data),
        .tx_sop      (tx_sop),
        .tx_eop      (tx_eop),
        .busy        (busy),
        .hw_head_we  (hw_head_we),
        .hw_head_val (hw_head_val),
        .hw_done     (hw_done),
        .hw_done_ptr (hw_done_ptr),
        .hw_fault    (hw_fault)
    );

    assign ch_busy = busy;

    // R6: an end-of-queue write-back leaves the head register empty
    a_r6_eoq_empties_head: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_wdata[EOQ_BIT]) |=> (head == '0));
endmodule

// File: tb/txq_dma_chan_tb.sv
`timescale 1ns/1ps
module txq_dma_chan_tb_top;
    localparam int PTR_W = 8;
    localparam int MEMW  = 1 << PTR_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [1:0] reg_wsel = '0;
    logic [31:0] reg_wdata = '0;
    logic [1:0] reg_rsel = '0;
    logic [31:0] reg_rdata;
    logic mem_req, mem_we;
    logic [PTR_W-1:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic tx_valid, tx_sop, tx_eop;
    logic tx_ready = 1'b1;
    logic [7:0] tx_data;
    logic ch_busy, ch_fault, cmpl_pending;

    txq_dma_chan #(.PTR_W(PTR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wsel(reg_wsel),
        .reg_wdata(reg_wdata), .reg_rsel(reg_rsel), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_data(tx_data), .tx_sop(tx_sop),
        .tx_eop(tx_eop), .ch_busy(ch_busy), .ch_fault(ch_fault),
        .cmpl_pending(cmpl_pending)
    );

    always #10 clk = ~clk;

    logic [31:0] mem [MEMW];
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr];
        end
    end

    int n_chk = 0;
    int n_err = 0;
    bit hold_ready = 0;
    bit stall_mode = 0;
    int cyc = 0;

    always @(posedge clk) begin
        cyc++;
        #2;
        if (hold_ready)      tx_ready = 1'b0;
        else if (stall_mode) tx_ready = (cyc % 3) != 0;
        else                 tx_ready = 1'b1;
    end

    logic [7:0] cap_b [64];
    bit cap_s [64];
    bit cap_e [64];
    int cap_n = 0;
    always @(negedge clk) begin
        if (rst_n && tx_valid && tx_ready && cap_n < 64) begin
            cap_b[cap_n] = tx_data;
            cap_s[cap_n] = tx_sop;
            cap_e[cap_n] = tx_eop;
            cap_n++;
        end
    end

    function automatic logic [7:0] pat(input int x);
        return 8'((x * 37 + 5) & 255);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_wsel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] d);
        reg_rsel = sel;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        int n = 0;
        repeat (3) @(negedge clk);
        while (ch_busy && n < 3000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 3000) chk(0, "watchdog wait_idle", 32'(n), 0);
    endtask

    task automatic put_desc(input int d, input int nxt, input int bp, input int len, input logic [31:0] mode);
        mem[d] = 32'(nxt); mem[d+1] = 32'(bp); mem[d+2] = 32'(len); mem[d+3] = mode;
    endtask

    function automatic logic [31:0] mk_mode(input bit own, input bit s, input bit e, input int len);
        return {s, e, own, 1'b0, 17'd0, 11'(len)};
    endfunction

    function automatic logic [31:0] wb_exp(input logic [31:0] m, input bit last);
        logic [31:0] r = m;
        r[29] = 1'b0;
        r[28] = last;
        return r;
    endfunction

    logic [31:0] v;

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        for (int a = 0; a < MEMW; a++)
            mem[a] = {pat(4*a+3), pat(4*a+2), pat(4*a+1), pat(4*a)};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd1, v); chk(v == 0, "R1 head after reset", v, 0);
        rd(2'd0, v); chk(v == 0, "R1 control after reset", v, 0);
        rd(2'd2, v); chk(v == 0, "R1 completion after reset", v, 0);
        chk({tx_valid, ch_busy, ch_fault, cmpl_pending} == 0, "R1 outputs after reset",
            {tx_valid, ch_busy, ch_fault, cmpl_pending}, 0);

        wr(2'd0, 1);

        // R2 R3 R5 R6 R9 sweep: length x flags x backpressure
        for (int L = 0; L < 10; L++) begin
            for (int f = 0; f < 4; f++) begin
                logic [31:0] m;
                bit okb, oks, oke;
                m = mk_mode(1, f[0], f[1], L);
                put_desc(16, 0, 64 + L, L, m);
                stall_mode = ((L + f) % 2) == 1;
                cap_n = 0;
                wr(2'd1, 16);
                wait_idle();
                chk(cap_n == L, "R3 byte count", 32'(cap_n), 32'(L));
                okb = 1; oks = 1; oke = 1;
                for (int i = 0; i < cap_n; i++) begin
                    if (cap_b[i] != pat((64 + L) * 4 + i)) okb = 0;
                    if (cap_s[i] != (f[0] && i == 0)) oks = 0;
                    if (cap_e[i] != (f[1] && i == L - 1)) oke = 0;
                end
                chk(okb, "R2/R3 byte values", 32'(L), 32'(f));
                chk(oks && oke, "R3 sop/eop marks", {oks, oke}, 2'b11);
                chk(mem[19] == wb_exp(m, 1), "R5 write-back mode word", mem[19], wb_exp(m, 1));
                rd(2'd1, v); chk(v == 0, "R6 head clear at end of chain", v, 0);
                chk(cmpl_pending == 1, "R9 pending after completion", 32'(cmpl_pending), 1);
                wr(2'd2, 17);
                chk(cmpl_pending == 1, "R9 wrong ack keeps pending", 32'(cmpl_pending), 1);
                wr(2'd2, 16);
                chk(cmpl_pending == 0, "R9 matching ack clears", 32'(cmpl_pending), 0);
            end
        end
        stall_mode = 0;

        // R7 chain of three descriptors
        begin
            int lens [3] = '{5, 8, 3};
            int bps  [3] = '{80, 96, 112};
            int ds   [3] = '{32, 36, 40};
            logic [31:0] ms [3];
            int k = 0;
            bit ok = 1;
            for (int j = 0; j < 3; j++) begin
                ms[j] = mk_mode(1, j == 0, j == 2, 16);
                put_desc(ds[j], (j < 2) ? ds[j+1] : 0, bps[j], lens[j], ms[j]);
            end
            stall_mode = 1;
            cap_n = 0;
            wr(2'd1, 32);
            wait_idle();
            stall_mode = 0;
            chk(cap_n == 16, "R7 chain byte count", 32'(cap_n), 16);
            for (int j = 0; j < 3; j++)
                for (int i = 0; i < lens[j]; i++) begin
                    if (k >= cap_n || cap_b[k] != pat(bps[j] * 4 + i)) ok = 0;
                    k++;
                end
            chk(ok, "R7 chain byte order", 32'(cap_n), 16);
            chk(cap_s[0] && cap_e[15] && !cap_s[5] && !cap_e[4], "R7 chain packet marks",
                {cap_s[0], cap_e[15], cap_s[5], cap_e[4]}, 4'b1100);
            for (int j = 0; j < 3; j++)
                chk(mem[ds[j]+3] == wb_exp(ms[j], j == 2), "R5/R6 chain write-backs",
                    mem[ds[j]+3], wb_exp(ms[j], j == 2));
            wr(2'd2, 36);
            chk(cmpl_pending == 1, "R9 ack of earlier descriptor", 32'(cmpl_pending), 1);
            wr(2'd2, 40);
            chk(cmpl_pending == 0, "R9 ack of last descriptor", 32'(cmpl_pending), 0);
        end

        // R8 ownership fault
        begin
            logic [31:0] m;
            m = mk_mode(0, 1, 1, 4);
            put_desc(48, 0, 64, 4, m);
            cap_n = 0;
            wr(2'd1, 48);
            wait_idle();
            chk(ch_fault == 1, "R8 fault flag", 32'(ch_fault), 1);
            chk(cap_n == 0, "R8 nothing sent", 32'(cap_n), 0);
            chk(mem[51] == m, "R8 no write-back", mem[51], m);
            rd(2'd1, v); chk(v == 0, "R8 head clear after fault", v, 0);
            put_desc(16, 0, 64, 2, mk_mode(1, 1, 1, 2));
            wr(2'd1, 16);
            chk(ch_fault == 0, "R8 head write clears fault", 32'(ch_fault), 0);
            wait_idle();
            wr(2'd2, 16);
        end

        // R10 disabled channel waits
        begin
            logic [31:0] m;
            m = mk_mode(1, 1, 1, 4);
            put_desc(16, 0, 70, 4, m);
            wr(2'd0, 0);
            cap_n = 0;
            wr(2'd1, 16);
            repeat (30) @(negedge clk);
            chk(cap_n == 0 && mem[19] == m, "R10 disabled sends nothing", 32'(cap_n), 0);
            rd(2'd1, v); chk(v == 16, "R10 head kept while disabled", v, 16);
            wr(2'd0, 1);
            wait_idle();
            chk(cap_n == 4 && mem[19] == wb_exp(m, 1), "R10 runs once enabled", 32'(cap_n), 4);
            wr(2'd2, 16);
        end

        // R12 head write while busy ignored
        begin
            logic [31:0] m2;
            m2 = mk_mode(1, 1, 1, 3);
            put_desc(16, 0, 72, 6, mk_mode(1, 1, 1, 6));
            put_desc(52, 0, 74, 3, m2);
            hold_ready = 1;
            cap_n = 0;
            wr(2'd1, 16);
            repeat (20) @(negedge clk);
            wr(2'd1, 52);
            rd(2'd1, v); chk(v == 16, "R12 head unchanged while busy", v, 16);
            hold_ready = 0;
            wait_idle();
            repeat (10) @(negedge clk);
            chk(cap_n == 6 && mem[55] == m2, "R12 second descriptor untouched", mem[55], m2);
            wr(2'd2, 16);
        end

        // R11 soft reset mid-packet
        begin
            logic [31:0] m;
            m = mk_mode(1, 1, 1, 6);
            put_desc(16, 0, 72, 6, m);
            hold_ready = 1;
            wr(2'd1, 16);
            repeat (20) @(negedge clk);
            wr(2'd2, 9);
            wr(2'd3, 1);
            rd(2'd3, v); chk(v == 1, "R11 soft reset bit reads set", v, 1);
            @(negedge clk);
            rd(2'd3, v); chk(v == 0, "R11 soft reset bit self-clears", v, 0);
            rd(2'd1, v); chk(v == 0, "R11 head cleared", v, 0);
            rd(2'd2, v); chk(v == 0, "R11 completion cleared", v, 0);
            chk({ch_busy, tx_valid, cmpl_pending, ch_fault} == 0, "R11 channel at rest",
                {ch_busy, tx_valid, cmpl_pending, ch_fault}, 0);
            chk(mem[19] == m, "R11 no write-back after abort", mem[19], m);
            hold_ready = 0;
        end

        // R6 late append needs a head rewrite
        begin
            logic [31:0] mb;
            put_desc(16, 0, 64, 2, mk_mode(1, 1, 1, 2));
            cap_n = 0;
            wr(2'd1, 16);
            wait_idle();
            mb = mk_mode(1, 1, 1, 3);
            put_desc(20, 0, 66, 3, mb);
            mem[16] = 20;
            repeat (10) @(negedge clk);
            chk(mem[19][28] == 1 && cap_n == 2 && mem[23] == mb, "R6 late append not fetched",
                mem[23], mb);
            wr(2'd1, 20);
            wait_idle();
            chk(cap_n == 5 && mem[23] == wb_exp(mb, 1), "R6 restart by head rewrite",
                32'(cap_n), 5);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule